// File: doc/BRIEF.md
# Cascadable Synchronous Binary Up-Counter

This block is a presettable binary up-counter whose width is a parameter (4 bits by default). It has a rising-edge clock, an active-low synchronous clear and an active-low synchronous parallel preset from a data bus. Two active-high enables must both be high for it to count. Only one of them, the carry enable, also gates the terminal-count output.

Each edge selects one of four operating modes. The modes are named `MODE_CLEAR`, `MODE_LOAD`, `MODE_COUNT` and `MODE_HOLD`, and they are decided in that strict priority order. The mode decoder evaluates them from scratch on every edge, so there are no transitions other than the per-edge choice of mode. The registered count moves to zero, to the preset value, to the count plus one, or stays unchanged.

The carry output is combinational. It is the carry enable ANDed with every count bit. To build a wider counter, feed one stage's carry output into the next stage's carry enable and share the count-only enable across all stages. Each stage then advances exactly when every lower stage is at all ones, with no ripple of clocks between stages. The count is undefined after power-up until the first clear or preset.

Top module: `cascade_bin_counter`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, every bit of `cnt` becomes 0 after that edge, whatever `ld_n`, the enables and `din` are.
- R2: When `clr_n` is 1 and `ld_n` is 0 at a rising edge, `cnt` takes `din` after that edge, with `din[i]` going to `cnt[i]` (bit 0 least significant), whatever the enables are.
- R3: When `clr_n` and `ld_n` are both 1 and both `cnt_en` and `cry_en` are 1 at a rising edge, `cnt` increases by exactly one.
- R4: When `clr_n` and `ld_n` are both 1 and either `cnt_en` or `cry_en` is 0 at a rising edge, `cnt` keeps its value.
- R5: Counting from all ones wraps `cnt` to zero on the next enabled edge.
- R6: `cry_out` equals `cry_en` ANDed with every bit of `cnt`, at all times. `cnt_en` has no effect on `cry_out`.
- R7: In a two-stage cascade, the low stage's `cry_out` drives the high stage's `cry_en`, and the high stage's `cnt_en` is taken from the low stage's `cnt_en`. The pair then counts, presets, holds and wraps as one binary counter of twice the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge only |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel preset, active low |
| cnt_en | input | 1 | Count enable that does not affect the carry |
| cry_en | input | 1 | Count enable that also gates the carry output |
| din | input | WIDTH | Preset value |
| cnt | output | WIDTH | Registered count value |
| cry_out | output | 1 | Terminal-count carry: `cry_en` AND all count bits |

## Verification
The assertions assume the count is unknown until the first clear or preset. They stay disabled until the checker has seen a clear or preset edge. The bench therefore opens with a clear, and it drives `clr_n`, `ld_n`, the enables and `din` only at falling edges, so every input is stable at the rising edge that samples it. The stimulus deliberately sets the two enables to different values. This separates the count-gating role of each enable from the carry-gating role of `cry_en`.

// File: rtl/cascade_bin_counter_pkg.sv
package cascade_bin_counter_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_COUNT = 2'd2,
        MODE_HOLD  = 2'd3
    } ctr_mode_e;

endpackage

// File: rtl/ctr_mode_sel.sv
module ctr_mode_sel
    import cascade_bin_counter_pkg::*;
(
    input  logic      clr_n,
    input  logic      ld_n,
    input  logic      cnt_en,
    input  logic      cry_en,
    output ctr_mode_e mode
);
    // Fixed priority: clear over preset over count over hold.
    always_comb begin
        if (!clr_n)
            mode = MODE_CLEAR;
        else if (!ld_n)
            mode = MODE_LOAD;
        else if (cnt_en && cry_en)
            mode = MODE_COUNT;
        else
            mode = MODE_HOLD;
    end
endmodule

// File: rtl/ctr_next.sv
module ctr_next
    import cascade_bin_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  ctr_mode_e          mode,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   din,
    output logic [WIDTH-1:0]   nxt
);
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ZERO = '0;

    always_comb begin
        unique case (mode)
            MODE_CLEAR: nxt = ZERO;
            MODE_LOAD:  nxt = din;
            MODE_COUNT: nxt = cur + ONE;
            MODE_HOLD:  nxt = cur;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_carry.sv
module ctr_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             cry_en,
    output logic             cry_out
);
    // AND chain, one link per bit, seeded by the carry enable.
    logic [WIDTH:0] chain;
    assign chain[0] = cry_en;

    for (genvar i = 0; i < WIDTH; i++) begin : g_and
        assign chain[i+1] = chain[i] & cur[i];
    end

    assign cry_out = chain[WIDTH];
endmodule

// File: rtl/cascade_bin_counter.sv
module cascade_bin_counter
    import cascade_bin_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ld_n,
    input  logic             cnt_en,
    input  logic             cry_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cnt,
    output logic             cry_out
);
    ctr_mode_e        mode;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;

    ctr_mode_sel u_mode (
        .clr_n  (clr_n),
        .ld_n   (ld_n),
        .cnt_en (cnt_en),
        .cry_en (cry_en),
        .mode   (mode)
    );

    ctr_next #(.WIDTH(WIDTH)) u_next (
        .mode (mode),
        .cur  (cnt_q),
        .din  (din),
        .nxt  (cnt_d)
    );

    // State register; clear is folded into the next-value mux (synchronous).
    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    ctr_carry #(.WIDTH(WIDTH)) u_carry (
        .cur     (cnt_q),
        .cry_en  (cry_en),
        .cry_out (cry_out)
    );

    assign cnt = cnt_q;
endmodule

// File: rtl/cascade_bin_counter_chk.sv
module cascade_bin_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             ld_n,
    input logic             cnt_en,
    input logic             cry_en,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] cnt,
    input logic             cry_out
);
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ONES = '1;

    // The count is defined once a clear or preset edge has occurred.
    logic primed = 1'b0;
    always_ff @(posedge clk) begin
        primed <= primed | ~clr_n | ~ld_n;
    end

    a_r1_clear_zero: assert property (@(posedge clk) disable iff (!primed)
        !clr_n |=> cnt == '0);

    a_r2_load_din: assert property (@(posedge clk) disable iff (!primed)
        (clr_n && !ld_n) |=> cnt == $past(din));

    a_r3_count_step: assert property (@(posedge clk) disable iff (!primed)
        (clr_n && ld_n && cnt_en && cry_en) |=> cnt == $past(cnt) + ONE);

    a_r4_hold_value: assert property (@(posedge clk) disable iff (!primed)
        (clr_n && ld_n && !(cnt_en && cry_en)) |=> $stable(cnt));

    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!primed)
        (clr_n && ld_n && cnt_en && cry_en && cnt == ONES) |=> cnt == '0);

    a_r6_carry_term: assert property (@(posedge clk) disable iff (!primed)
        cry_out == (cry_en && (cnt == ONES)));
endmodule

bind cascade_bin_counter cascade_bin_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .clr_n   (clr_n),
    .ld_n    (ld_n),
    .cnt_en  (cnt_en),
    .cry_en  (cry_en),
    .din     (din),
    .cnt     (cnt),
    .cry_out (cry_out)
);

// File: tb/test_cascade_bin_counter.sv
`timescale 1ns/1ps
module test_cascade_bin_counter;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         ld_n = 1'b1;
    logic         en_a = 1'b0;   // count-only enable, shared by both stages
    logic         en_b = 1'b0;   // carry enable of the low stage
    logic [2*W-1:0] d = '0;
    logic [W-1:0] lo_q, hi_q;
    logic         lo_cy, hi_cy;

    integer total = 0;
    integer bad = 0;
    bit     done = 1'b0;
    int     model = 0;

    always #10 clk = ~clk;

    cascade_bin_counter #(.WIDTH(W)) i_cascade_bin_counter (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .cnt_en(en_a), .cry_en(en_b),
        .din(d[W-1:0]), .cnt(lo_q), .cry_out(lo_cy)
    );

    cascade_bin_counter #(.WIDTH(W)) i_cascade_bin_counter_hi (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .cnt_en(en_a), .cry_en(lo_cy),
        .din(d[2*W-1:W]), .cnt(hi_q), .cry_out(hi_cy)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // Carry expectations from the model value and the current enables.
    task automatic chk_carry(input string tag);
        int lo_all, hi_all;
        lo_all = ((model & 15) == 15) ? 1 : 0;
        hi_all = ((model >> 4) == 15) ? 1 : 0;
        chk({tag, " lo carry"}, int'(lo_cy), int'(en_b) & lo_all);
        chk({tag, " hi carry"}, int'(hi_cy), int'(en_b) & lo_all & hi_all);
    endtask

    // Drive at a falling edge, check the carry, clock once, check the count.
    task automatic step(input bit c, input bit l, input bit a, input bit b,
                        input int val, input string tag);
        clr_n = c; ld_n = l; en_a = a; en_b = b; d = val[2*W-1:0];
        #1;
        chk_carry(tag);
        @(posedge clk);
        if (!c)          model = 0;
        else if (!l)     model = val & 255;
        else if (a && b) model = (model + 1) & 255;
        @(negedge clk);
        chk({tag, " count"}, int'({hi_q, lo_q}), model);
    endtask

    initial begin
        @(negedge clk);
        // R1: clear wins over preset and enables
        step(0, 0, 1, 1, 8'hA5, "R1");
        chk("R1 reset lo", int'(lo_q), 0);
        // R2: preset with enables off, and with enables on
        step(1, 0, 0, 0, 8'h3C, "R2");
        step(1, 0, 1, 1, 8'h96, "R2");
        // R3: counting
        for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 0, "R3");
        // R4: hold with either enable low
        step(1, 1, 0, 1, 0, "R4");
        step(1, 1, 1, 0, 0, "R4");
        step(1, 1, 0, 0, 0, "R4");
        // R6: carry follows cry_en only; cnt_en irrelevant
        step(1, 0, 0, 0, 8'h0F, "R6");
        step(1, 1, 0, 1, 0, "R6");
        step(1, 1, 1, 0, 0, "R6");
        step(1, 1, 0, 1, 0, "R6");
        // R5/R7: cascade wraps through all ones
        step(1, 0, 0, 0, 8'hFD, "R7");
        for (int i = 0; i < 4; i++) step(1, 1, 1, 1, 0, "R5");
        // R7: long run as one 8-bit counter with mixed enables
        for (int i = 0; i < 600; i++)
            step(1, 1, (i % 7) != 3, (i % 11) != 5, 0, "R7");
        // R1: clear in mid-count
        step(0, 1, 1, 1, 0, "R1");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule